// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. It drives the clock-enable pin and the command/bank/address bus through the power-up and mode-programming sequence the memory needs before it can take any traffic. Software starts the sequence by writing a configuration register. That write appears here as a one-cycle `cfg_write` pulse. Reset on its own leaves the bus idle with clock-enable low.

The mode and extended-mode words are assembled from live configuration fields: CAS latency, write recovery, termination select, drive strength, differential strobe and DLL disable. The first run opens with a long settling wait derived from the refresh interval. After it, clock-enable is raised and the command list is issued with programmable minimum spacing. A later `cfg_write` reruns the command list from the first precharge and rewrites every mode register with the current fields. That rerun keeps clock-enable high and skips the settling wait. `init_done` is the ready flag for the traffic side: no normal transaction may be started while it is low. The block has no streaming interface; every pin is a plain level or pulse.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, `cke` is 0, `cmd_rcw` is NOP (111), `init_done` is 0. This state holds with no command issued for as long as `cfg_write` stays low.
- R2: On the first `cfg_write` after reset, `cke` stays 0 until 16*`refresh_rate`+8 cycles after the trigger edge and then rises. The first command follows T_CKE+1 cycles after that rise. No command other than NOP is ever driven while `cke` is 0.
- R3: The command list is fixed, with `cmd_rcw` encoded as {RAS#,CAS#,WE#}: PRE=010, LMR=000, REF=001, NOP=111. The list is: PRE with `addr[10]`=1; LMR to bank 2 with addr 0; LMR to bank 3 with addr 0; LMR bank 1; LMR bank 0; PRE with `addr[10]`=1; REF; REF; LMR bank 0; LMR bank 1; LMR bank 1. PRE and REF use bank 0, and REF uses addr 0.
- R4: The spacing from one command to the next is T_RP after a PRE, T_RFC after a REF and T_MRD after an LMR. NOP fills every cycle in between.
- R5: The bank-1 word (step 4) is built as follows. Bit 10 = `dqs_diff`. Bit 6 = `odt_sel[1]`. Bit 2 = `odt_sel[0]`. Bit 1 = `drv_str[0]`. Bit 0 = `dll_off`. Bits 9:7 = 000. All other bits are 0.
- R6: The first bank-0 word (step 5) is built as follows. Bits 11:9 = `wr_recov`. Bit 8 = 1. Bits 6:4 = `cas_lat[2:0]`. Bits 2:0 = 011. All other bits are 0.
- R7: The second bank-0 word (step 9) equals the first with bit 8 cleared.
- R8: The last two bank-1 writes repeat the R5 word. The first of them has bits 9:7 = 111 and the second has bits 9:7 = 000.
- R9: `cas_lat[3]`, `odt_sel[2]` and `drv_str[1]` have no effect on any issued word.
- R10: A `cfg_write` seen while `init_done` is 1 keeps `cke` high and issues the first PRE one cycle after the trigger edge. All words are rebuilt from the fields present at that time.
- R11: `init_done` rises exactly T_MRD cycles after the final LMR appears and stays 0 while any command of the list is issued. It drops in the cycle after a `cfg_write` edge that arrives while it is 1.
- R12: A `cfg_write` that arrives while a run is in progress is held. When the run ends, `init_done` stays 0 and a rerun's first PRE follows T_MRD+1 cycles after the final LMR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_write | input | 1 | One-cycle pulse on a configuration register write |
| cas_lat | input | 4 | CAS latency field (top bit unused) |
| wr_recov | input | 3 | Write recovery field |
| odt_sel | input | 3 | Termination select (top bit unused) |
| drv_str | input | 2 | Drive strength (top bit unused) |
| dqs_diff | input | 1 | Differential strobe enable |
| dll_off | input | 1 | DLL disable bit placed in the bank-1 word |
| refresh_rate | input | RR_W | Refresh interval in cycles, scales the first wait |
| cke | output | 1 | SDRAM clock enable |
| cmd_rcw | output | 3 | {RAS#,CAS#,WE#} command code |
| bank | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/mode address |
| init_done | output | 1 | Sequence complete; traffic may start |

## Verification
The checker assumes that the configuration fields hold still whenever `cke` is high and `init_done` is low. It also assumes that each timing parameter is at least 2, so two commands never sit back-to-back. The stimulus only changes fields at least one full clock before a `cfg_write` pulse, and only while the block is idle or finished. The one mid-run pulse leaves the fields untouched. Every expected word is computed arithmetically from the low field bits. The sweeps set the ignored top bits freely, so any leakage from them shows up as a word mismatch.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_CKE,
    ST_RUN,
    ST_TAIL,
    ST_DONE
  } seq_state_t;

  // {RAS#, CAS#, WE#}
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_LMR = 3'b000;
  localparam logic [2:0] CMD_REF = 3'b001;

  localparam int WORD_W      = 16;
  localparam int STEPS       = 11;
  localparam int STEP_W      = 4;
  localparam int PRE_ALL_BIT = 10;

  localparam logic [2:0] OCD_EXIT = 3'b000;
  localparam logic [2:0] OCD_DFLT = 3'b111;

endpackage

// File: rtl/ddr2_mode_words.sv
module ddr2_mode_words
  import ddr2_init_pkg::*;
(
  input  logic [2:0]        cl_lo,
  input  logic [2:0]        wr,
  input  logic [1:0]        odt_lo,
  input  logic              drv_lo,
  input  logic              dqs_diff,
  input  logic              dll_off,
  input  logic [2:0]        ocd,
  input  logic              dll_rst,
  output logic [WORD_W-1:0] emr1_word,
  output logic [WORD_W-1:0] mr_word
);

  // bank-1 word: strobe mode, OCD field, split termination bits, drive, DLL
  assign emr1_word = {3'b000, 1'b0, 1'b0, dqs_diff, ocd, odt_lo[1],
                      3'b000, odt_lo[0], drv_lo, dll_off};

  // bank-0 word: write recovery, DLL reset, CAS latency, sequential burst of 8
  assign mr_word = {3'b000, 1'b0, wr, dll_rst, 1'b0, cl_lo, 1'b0, 3'b011};

endmodule

// File: rtl/ddr2_step_decode.sv
module ddr2_step_decode
  import ddr2_init_pkg::*;
#(
  parameter int T_RP   = 4,
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 12,
  parameter int GAP_W  = 8,
  parameter int BA_W   = 3,
  parameter int ADDR_W = 16
) (
  input  logic [STEP_W-1:0] step,
  input  logic [2:0]        cl_lo,
  input  logic [2:0]        wr,
  input  logic [1:0]        odt_lo,
  input  logic              drv_lo,
  input  logic              dqs_diff,
  input  logic              dll_off,
  output logic [2:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [GAP_W-1:0]  gap
);

  logic [2:0]        ocd;
  logic              dll_rst;
  logic [WORD_W-1:0] emr1_word;
  logic [WORD_W-1:0] mr_word;

  assign ocd     = (step == STEP_W'(9)) ? OCD_DFLT : OCD_EXIT;
  assign dll_rst = (step == STEP_W'(4));

  ddr2_mode_words u_words (
    .cl_lo    (cl_lo),
    .wr       (wr),
    .odt_lo   (odt_lo),
    .drv_lo   (drv_lo),
    .dqs_diff (dqs_diff),
    .dll_off  (dll_off),
    .ocd      (ocd),
    .dll_rst  (dll_rst),
    .emr1_word(emr1_word),
    .mr_word  (mr_word)
  );

  always_comb begin
    cmd  = CMD_LMR;
    ba   = '0;
    addr = '0;
    gap  = GAP_W'(T_MRD);
    case (step)
      4'd0, 4'd5: begin
        cmd               = CMD_PRE;
        addr[PRE_ALL_BIT] = 1'b1;
        gap               = GAP_W'(T_RP);
      end
      4'd1: ba = BA_W'(2);
      4'd2: ba = BA_W'(3);
      4'd3, 4'd9, 4'd10: begin
        ba   = BA_W'(1);
        addr = ADDR_W'(emr1_word);
      end
      4'd4, 4'd8: addr = ADDR_W'(mr_word);
      4'd6, 4'd7: begin
        cmd = CMD_REF;
        gap = GAP_W'(T_RFC);
      end
      default: begin
        cmd = CMD_NOP;
        gap = GAP_W'(1);
      end
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int T_RP   = 4,    // PRE to next command, >= 2
  parameter int T_MRD  = 2,    // LMR to next command, >= 2
  parameter int T_RFC  = 12,   // REF to next command, >= 2
  parameter int T_CKE  = 100,  // cke high before first command (400 ns at 4 ns)
  parameter int RR_W   = 16,
  parameter int BA_W   = 3,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_write,
  input  logic [3:0]        cas_lat,
  input  logic [2:0]        wr_recov,
  input  logic [2:0]        odt_sel,
  input  logic [1:0]        drv_str,
  input  logic              dqs_diff,
  input  logic              dll_off,
  input  logic [RR_W-1:0]   refresh_rate,
  output logic              cke,
  output logic [2:0]        cmd_rcw,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int CNT_W     = RR_W + 5;
  localparam int GAP_W     = 8;
  localparam int LAST_STEP = STEPS - 1;

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] step;
  logic              pend;
  logic              running;
  logic [CNT_W-1:0]  pwr_wait;

  logic [2:0]        dec_cmd;
  logic [BA_W-1:0]   dec_ba;
  logic [ADDR_W-1:0] dec_addr;
  logic [GAP_W-1:0]  dec_gap;

  // 16 refresh intervals plus 8 cycles, minus one for the load cycle
  assign pwr_wait = {1'b0, refresh_rate, 4'b0000} + CNT_W'(7);
  assign running  = (state == ST_PWR) || (state == ST_CKE) ||
                    (state == ST_RUN) || (state == ST_TAIL);

  ddr2_step_decode #(
    .T_RP  (T_RP),
    .T_MRD (T_MRD),
    .T_RFC (T_RFC),
    .GAP_W (GAP_W),
    .BA_W  (BA_W),
    .ADDR_W(ADDR_W)
  ) u_dec (
    .step    (step),
    .cl_lo   (cas_lat[2:0]),
    .wr      (wr_recov),
    .odt_lo  (odt_sel[1:0]),
    .drv_lo  (drv_str[0]),
    .dqs_diff(dqs_diff),
    .dll_off (dll_off),
    .cmd     (dec_cmd),
    .ba      (dec_ba),
    .addr    (dec_addr),
    .gap     (dec_gap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      step      <= '0;
      pend      <= 1'b0;
      cke       <= 1'b0;
      cmd_rcw   <= CMD_NOP;
      bank      <= '0;
      addr      <= '0;
      init_done <= 1'b0;
    end else begin
      cmd_rcw <= CMD_NOP;
      bank    <= '0;
      addr    <= '0;
      if (cfg_write && running) pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (cfg_write) begin
            state <= ST_PWR;
            cnt   <= pwr_wait;
          end
        end
        ST_PWR: begin
          if (cnt == '0) begin
            state <= ST_CKE;
            cke   <= 1'b1;
            cnt   <= CNT_W'(T_CKE - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_CKE: begin
          if (cnt == '0) begin
            state <= ST_RUN;
            step  <= '0;
          end else cnt <= cnt - 1'b1;
        end
        ST_RUN: begin
          if (cnt == '0) begin
            cmd_rcw <= dec_cmd;
            bank    <= dec_ba;
            addr    <= dec_addr;
            cnt     <= CNT_W'(dec_gap) - CNT_W'(1);
            if (step == STEP_W'(LAST_STEP)) state <= ST_TAIL;
            else step <= step + 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_TAIL: begin
          if (cnt == '0) begin
            step <= '0;
            if (pend || cfg_write) begin
              state <= ST_RUN;
              pend  <= 1'b0;
            end else begin
              state     <= ST_DONE;
              init_done <= 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        ST_DONE: begin
          cnt <= '0;
          if (cfg_write) begin
            state     <= ST_RUN;
            step      <= '0;
            init_done <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk
  import ddr2_init_pkg::*;
#(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_write,
  input logic [3:0]        cas_lat,
  input logic [2:0]        wr_recov,
  input logic [2:0]        odt_sel,
  input logic [1:0]        drv_str,
  input logic              dqs_diff,
  input logic              dll_off,
  input logic              cke,
  input logic [2:0]        cmd_rcw,
  input logic [BA_W-1:0]   bank,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  // R2
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd_rcw == CMD_NOP);

  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cke));

  // R3
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rcw == CMD_PRE |-> addr[PRE_ALL_BIT]);

  // R3
  ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rcw == CMD_REF |-> (bank == '0 && addr == '0));

  // R4
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rcw != CMD_NOP |=> cmd_rcw == CMD_NOP);

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rcw != CMD_NOP |-> !init_done);

  // R11
  retrig_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_write && init_done) |=> !init_done);

  // R10 input assumption: fields hold still while a command list runs
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !init_done) |->
      $stable({cas_lat, wr_recov, odt_sel, drv_str, dqs_diff, dll_off}));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_write(cfg_write),
  .cas_lat  (cas_lat),
  .wr_recov (wr_recov),
  .odt_sel  (odt_sel),
  .drv_str  (drv_str),
  .dqs_diff (dqs_diff),
  .dll_off  (dll_off),
  .cke      (cke),
  .cmd_rcw  (cmd_rcw),
  .bank     (bank),
  .addr     (addr),
  .init_done(init_done)
);

// File: tb/ddr2_init_seq_test.sv
module ddr2_init_seq_test;

  localparam int T_RP  = 4;
  localparam int T_MRD = 2;
  localparam int T_RFC = 12;
  localparam int T_CKE = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_write = 1'b0;
  logic [3:0]  cas_lat = '0;
  logic [2:0]  wr_recov = '0;
  logic [2:0]  odt_sel = '0;
  logic [1:0]  drv_str = '0;
  logic        dqs_diff = 1'b0;
  logic        dll_off = 1'b0;
  logic [15:0] refresh_rate = '0;
  logic        cke;
  logic [2:0]  cmd_rcw;
  logic [2:0]  bank;
  logic [15:0] addr;
  logic        init_done;

  always #2 clk = ~clk;

  ddr2_init_seq #(.T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .T_CKE(T_CKE)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_write(cfg_write), .cas_lat(cas_lat),
    .wr_recov(wr_recov), .odt_sel(odt_sel), .drv_str(drv_str),
    .dqs_diff(dqs_diff), .dll_off(dll_off), .refresh_rate(refresh_rate),
    .cke(cke), .cmd_rcw(cmd_rcw), .bank(bank), .addr(addr), .init_done(init_done)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int lc[0:31];
  int lb[0:31];
  int la[0:31];
  int lt[0:31];
  int nlog = 0;
  int arm = 32'h3fff_ffff;
  int done_cyc = -1;
  int cke_cyc = -1;
  int c_cl, c_wr, c_odt, c_drv, c_dqs, c_dll;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (cyc >= arm) begin
      if (cmd_rcw != 3'b111 && nlog < 32) begin
        lc[nlog] = cmd_rcw; lb[nlog] = bank; la[nlog] = addr; lt[nlog] = cyc;
        nlog++;
      end
      if (init_done && done_cyc < 0) done_cyc = cyc;
      if (cke && cke_cyc < 0) cke_cyc = cyc;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog: actual cycle %0d expected below 150000", cyc);
    summary();
    $finish;
  end

  task automatic chk(input string req, input int act, input int expv, input string what);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int gap_of(input int k);
    if (k == 0 || k == 5) return T_RP;
    if (k == 6 || k == 7) return T_RFC;
    return T_MRD;
  endfunction

  function automatic int cmd_of(input int k);
    if (k == 0 || k == 5) return 2;
    if (k == 6 || k == 7) return 1;
    return 0;
  endfunction

  function automatic int ba_of(input int k);
    if (k == 1) return 2;
    if (k == 2) return 3;
    if (k == 3 || k == 9 || k == 10) return 1;
    return 0;
  endfunction

  function automatic int addr_of(input int k);
    int emr1 = c_dqs * 1024 + ((c_odt >> 1) & 1) * 64 + (c_odt & 1) * 4 + (c_drv & 1) * 2 + c_dll;
    int mr = c_wr * 512 + (c_cl % 8) * 16 + 3;
    if (k == 0 || k == 5) return 1024;
    if (k == 3 || k == 10) return emr1;
    if (k == 9) return emr1 + 7 * 128;
    if (k == 4) return mr + 256;
    if (k == 8) return mr;
    return 0;
  endfunction

  function automatic string addr_tag(input int k);
    if (k == 3) return "R5";
    if (k == 4) return "R6";
    if (k == 8) return "R7";
    if (k == 9 || k == 10) return "R8";
    return "R3";
  endfunction

  task automatic verify(input int base, input int first_t, input string xtag, output int last_t);
    int t = first_t;
    for (int k = 0; k < 11; k++) begin
      chk("R3", lc[base+k], cmd_of(k), $sformatf("cmd step %0d", k));
      chk("R3", lb[base+k], ba_of(k), $sformatf("bank step %0d", k));
      chk({addr_tag(k), "/", xtag}, la[base+k], addr_of(k), $sformatf("addr step %0d", k));
      chk("R4", lt[base+k], t, $sformatf("issue cycle step %0d", k));
      last_t = t;
      t += gap_of(k);
    end
  endtask

  task automatic set_cfg(input int cl, input int wr, input int odt, input int drv,
                         input int dqs, input int dll);
    @(negedge clk);
    c_cl = cl; c_wr = wr; c_odt = odt; c_drv = drv; c_dqs = dqs; c_dll = dll;
    cas_lat = 4'(cl); wr_recov = 3'(wr); odt_sel = 3'(odt); drv_str = 2'(drv);
    dqs_diff = 1'(dqs); dll_off = 1'(dll);
  endtask

  task automatic fire();
    @(negedge clk);
    nlog = 0; done_cyc = -1; cke_cyc = -1;
    arm = cyc + 1;
    cfg_write = 1'b1;
    @(negedge clk);
    cfg_write = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (done_cyc < 0 && g < 3000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic do_reset(input int rr);
    rst_n = 1'b0;
    arm = 32'h3fff_ffff;
    refresh_rate = 16'(rr);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int last1, last2, rr, w;
    set_cfg(5, 3, 1, 0, 0, 0);
    do_reset(3);
    // R1 reset state and no self-start
    chk("R1", cke, 0, "cke after reset");
    chk("R1", cmd_rcw, 7, "cmd after reset");
    chk("R1", init_done, 0, "init_done after reset");
    nlog = 0; done_cyc = -1; cke_cyc = -1; arm = cyc;
    repeat (40) @(negedge clk);
    chk("R1", nlog, 0, "commands without trigger");
    chk("R1", cke_cyc, -1, "cke rise without trigger");
    chk("R1", done_cyc, -1, "done without trigger");

    // R2 first run with several refresh intervals
    for (int i = 0; i < 3; i++) begin
      rr = (i == 0) ? 3 : (i == 1) ? 0 : 5;
      do_reset(rr);
      set_cfg(4 + i, 2 + i, i, 1, i & 1, 0);
      fire();
      wait_done();
      w = 16 * rr + 8;
      chk("R2", cke_cyc, arm + w, "cke rise cycle");
      chk("R3", nlog, 11, "command count");
      verify(0, arm + w + T_CKE + 1, "R2", last1);
      chk("R11", done_cyc, last1 + T_MRD, "init_done rise");
    end

    // R6 R7 R9 R10 sweep of CAS latency and write recovery on reruns
    for (int cl = 0; cl < 16; cl++) begin
      for (int wr = 0; wr < 8; wr++) begin
        set_cfg(cl, wr, 2, 1, 1, 0);
        fire();
        wait_done();
        chk("R10", cke_cyc, arm, "cke high on rerun");
        chk("R3", nlog, 11, "command count");
        verify(0, arm + 1, (cl >= 8) ? "R9" : "R10", last1);
        chk("R11", done_cyc, last1 + T_MRD, "init_done rise");
      end
    end

    // R5 R8 R9 sweep of the bank-1 word fields
    for (int odt = 0; odt < 8; odt++)
      for (int drv = 0; drv < 4; drv++)
        for (int dqs = 0; dqs < 2; dqs++)
          for (int dll = 0; dll < 2; dll++) begin
            set_cfg(3, 5, odt, drv, dqs, dll);
            fire();
            wait_done();
            verify(0, arm + 1, (odt >= 4 || drv >= 2) ? "R9" : "R5", last1);
            chk("R11", done_cyc, last1 + T_MRD, "init_done rise");
          end

    // R12 trigger during a run is held and rerun follows
    set_cfg(6, 2, 2, 1, 1, 0);
    fire();
    repeat (20) @(negedge clk);
    cfg_write = 1'b1;
    @(negedge clk);
    cfg_write = 1'b0;
    wait_done();
    chk("R12", nlog, 22, "command count with held trigger");
    verify(0, arm + 1, "R12", last1);
    verify(11, last1 + T_MRD + 1, "R12", last2);
    chk("R12", done_cyc, last2 + T_MRD, "init_done after held rerun");

    summary();
    $finish;
  end

endmodule